// File: doc/BRIEF.md
# Capture and Auto-Reload Timer

A 16-bit up-counter with a companion 16-bit register pair. The counter advances either on an enable tick (one per machine cycle) or on falling edges of an external count pin. The companion pair works as a capture register or as a reload source, depending on a control bit. A falling edge on a trigger pin can either snapshot the counter into the pair or force the counter to reload from it. A baud-generator setting turns overflows into single-cycle receive and transmit clock pulses for a serial port. In that setting the timer always reloads on overflow and ignores the trigger pin.

Two sticky flags record events: one for overflow and one for a trigger event. Only software clears them. The interrupt request combines the two. An optional up/down setting lets the trigger pin's level choose the count direction, and in that setting the trigger flag does not request an interrupt. Software uses a plain byte-wide register port with a one-cycle write strobe and a combinational read. There is no streaming data path, so the block has no valid/ready handshake and never applies back-pressure.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, every readable register is 00h, `irq` is 0, and both baud pulses are 0.
- R2: Register map by `wr_addr`/`rd_addr`: 0 = control, 1 = mode (bit 0 = up/down enable), 2/3 = counter low/high, 4/5 = pair low/high, 6/7 read 00h. A written byte reads back unchanged, except where a same-cycle event sets a flag.
- R3: Control bits are, from MSB to LSB: overflow flag, trigger flag, receive-clock select, transmit-clock select, trigger enable, run, external-count select, capture select. In timer mode with run = 1, the counter adds one per `tick_en` cycle. With run = 0 it holds. A counter byte write takes precedence over counting in that cycle.
- R4: With external-count select = 1, the counter advances once per falling edge of `cnt_pin`. Each pin passes through two synchronising flops, and a falling edge is recognised on a tick where the synchronised level is 0 while the previous tick's sample was 1.
- R5: Capture mode (capture select = 1, no baud clock selected): when trigger enable = 1, a trigger falling edge copies the pre-event counter into the pair and sets the trigger flag. Overflow from FFFFh wraps the counter to 0000h and sets the overflow flag.
- R6: Reload mode (capture select = 0): overflow from FFFFh loads the counter from the pair and sets the overflow flag. With trigger enable = 1, a trigger falling edge also loads the counter from the pair and sets the trigger flag. With trigger enable = 0, trigger edges have no effect.
- R7: With either clock-select bit set, capture select is ignored and the counter reloads on overflow. Trigger edges cause no capture, no reload and no flag. The overflow flag stays clear. The next cycle after an overflow, `rx_clk_pulse` (receive select) and/or `tx_clk_pulse` (transmit select) is 1 for exactly one cycle.
- R8: The flags are sticky. Only a control write changes them, and it loads the written bits. If a set event occurs in the same cycle as the write, the event wins.
- R9: `irq` = overflow flag OR (trigger flag AND up/down enable = 0).
- R10: Up/down mode (up/down enable = 1, capture select = 0, no baud clock): the synchronised trigger level selects the direction, 1 = up and 0 = down. Counting up from FFFFh reloads from the pair. Counting down when the counter equals the pair loads FFFFh. Both cases set the overflow flag. Trigger edges cause no reload and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Machine-cycle enable; counting and pin sampling happen on it |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | Capture/reload trigger and up/down direction input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| rx_clk_pulse | output | 1 | Receive baud clock pulse |
| tx_clk_pulse | output | 1 | Transmit baud clock pulse |

## Verification
The hardest case to reach is a trigger falling edge arriving while the counter is also at its end value, so that capture or reload and overflow land in the same tick. A second hard case is the down-count match against the pair, which only happens when the synchronised trigger level is low for a long run of ticks. The stimulus preloads the counter a few counts below FFFFh, or a few above the pair, through the register port. It then drives repeated low pulses on the trigger pin, with different tick spacings, so the edges drift across the overflow tick. A behavioural reference model in the bench follows each register and flag every clock.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_CTRL   = 3'd0,
    A_MODE   = 3'd1,
    A_CNT_L  = 3'd2,
    A_CNT_H  = 3'd3,
    A_PAIR_L = 3'd4,
    A_PAIR_H = 3'd5
  } crt_addr_e;

  typedef struct packed {
    logic ovf;
    logic ext;
    logic rx_sel;
    logic tx_sel;
    logic trig_en;
    logic run;
    logic ext_cnt;
    logic cap_sel;
  } crt_ctrl_t;
endpackage

// File: rtl/crt_edge_sampler.sv
module crt_edge_sampler #(
  parameter int NPINS  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NPINS-1:0] pins,
  output logic [NPINS-1:0] level,
  output logic [NPINS-1:0] fall
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [STAGES-1:0] sh;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh   <= '1;
        prev <= 1'b1;
      end else begin
        sh <= {sh[STAGES-2:0], pins[g]};
        if (tick) prev <= sh[STAGES-1];
      end
    end
    assign level[g] = sh[STAGES-1];
    assign fall[g]  = tick & prev & ~sh[STAGES-1];
  end
endmodule

// File: rtl/crt_count_core.sv
module crt_count_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cnt_fall,
  input  logic          trig_fall,
  input  logic          trig_level,
  input  logic          run,
  input  logic          ext_cnt,
  input  logic          cap_sel,
  input  logic          trig_en,
  input  logic          rx_sel,
  input  logic          tx_sel,
  input  logic          updown,
  input  logic [1:0]    cnt_wr,
  input  logic [1:0]    pair_wr,
  input  logic [CW/2-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] pair,
  output logic          ovf_evt,
  output logic          ext_evt,
  output logic          rx_pulse,
  output logic          tx_pulse
);
  localparam int HW = CW / 2;
  localparam logic [CW-1:0] ALL1 = '1;

  logic baud, cap_mode, dn_mode, step, go_up, at_end, cnt_wr_any;
  logic [CW-1:0] cnt_nxt, pair_nxt;

  always_comb begin
    baud       = rx_sel | tx_sel;
    cap_mode   = cap_sel & ~baud;
    dn_mode    = updown & ~cap_sel & ~baud;
    cnt_wr_any = |cnt_wr;
    step       = run & (ext_cnt ? cnt_fall : tick) & ~cnt_wr_any;
    go_up      = ~dn_mode | trig_level;
    at_end     = go_up ? (cnt == ALL1) : (cnt == pair);
    ovf_evt    = step & at_end;
    ext_evt    = trig_fall & trig_en & ~baud & ~dn_mode;
  end

  always_comb begin
    cnt_nxt = cnt;
    if (ovf_evt)   cnt_nxt = go_up ? (cap_mode ? '0 : pair) : ALL1;
    else if (step) cnt_nxt = go_up ? cnt + 1'b1 : cnt - 1'b1;
    if (ext_evt && !cap_mode) cnt_nxt = pair;
    if (cnt_wr[0]) cnt_nxt[HW-1:0]  = wdata;
    if (cnt_wr[1]) cnt_nxt[CW-1:HW] = wdata;
  end

  always_comb begin
    pair_nxt = pair;
    if (ext_evt && cap_mode) pair_nxt = cnt;
    if (pair_wr[0]) pair_nxt[HW-1:0]  = wdata;
    if (pair_wr[1]) pair_nxt[CW-1:HW] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      pair     <= '0;
      rx_pulse <= 1'b0;
      tx_pulse <= 1'b0;
    end else begin
      cnt      <= cnt_nxt;
      pair     <= pair_nxt;
      rx_pulse <= ovf_evt & rx_sel;
      tx_pulse <= ovf_evt & tx_sel;
    end
  end

  // R3: a stopped counter with no write and no trigger reload keeps its value
  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr_any && !ext_evt) |=> $stable(cnt));

  // R5: the pair changes only by a write or a capture
  p_pair_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|pair_wr) && !(ext_evt && cap_mode)) |=> $stable(pair));

  // R6: upward overflow outside capture mode lands on the old pair value
  p_ovf_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && go_up && !cap_mode) |=> (cnt == $past(pair)));

  // R7: a receive pulse only follows a cycle with receive select set
  p_rx_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pulse |-> $past(rx_sel));
endmodule

// File: rtl/crt_ctrl_regs.sv
module crt_ctrl_regs
  import crt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_mode,
  input  logic [DW-1:0] wdata,
  input  logic          ovf_set,
  input  logic          ext_set,
  output crt_ctrl_t     ctrl,
  output logic          updown,
  output logic          irq
);
  crt_ctrl_t ctrl_nxt;

  always_comb begin
    ctrl_nxt = ctrl;
    if (wr_ctrl) ctrl_nxt = crt_ctrl_t'(wdata);
    if (ovf_set && !(ctrl.rx_sel || ctrl.tx_sel)) ctrl_nxt.ovf = 1'b1;
    if (ext_set) ctrl_nxt.ext = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      updown <= 1'b0;
    end else begin
      ctrl <= ctrl_nxt;
      if (wr_mode) updown <= wdata[0];
    end
  end

  assign irq = ctrl.ovf | (ctrl.ext & ~updown);

  // R8: flags are sticky without a control write
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.ovf && !wr_ctrl) |=> ctrl.ovf);
  p_ext_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.ext && !wr_ctrl) |=> ctrl.ext);

  // R7: no overflow flag while a baud clock is selected
  p_no_ovf_baud_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.ovf && !wr_ctrl && (ctrl.rx_sel || ctrl.tx_sel)) |=> !ctrl.ovf);
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int CW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          cnt_pin,
  input  logic          trig_pin,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          rx_clk_pulse,
  output logic          tx_clk_pulse
);
  localparam int HW = CW / 2;

  logic [1:0]    lvl, fall;
  logic          unused_cnt_level;
  crt_ctrl_t     ctrl;
  logic          updown, ovf_evt, ext_evt;
  logic [CW-1:0] cnt, pair;
  logic [1:0]    cnt_wr, pair_wr;
  logic          wr_ctrl, wr_mode;

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == A_CTRL);
    wr_mode = wr_en && (wr_addr == A_MODE);
    cnt_wr  = {wr_en && (wr_addr == A_CNT_H),  wr_en && (wr_addr == A_CNT_L)};
    pair_wr = {wr_en && (wr_addr == A_PAIR_H), wr_en && (wr_addr == A_PAIR_L)};
  end

  crt_edge_sampler #(.NPINS(2), .STAGES(STAGES)) u_pins (
    .clk(clk), .rst_n(rst_n), .tick(tick_en),
    .pins({trig_pin, cnt_pin}), .level(lvl), .fall(fall)
  );
  assign unused_cnt_level = lvl[0];

  crt_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_mode(wr_mode),
    .wdata(wr_data), .ovf_set(ovf_evt), .ext_set(ext_evt),
    .ctrl(ctrl), .updown(updown), .irq(irq)
  );

  crt_count_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_en),
    .cnt_fall(fall[0]), .trig_fall(fall[1]), .trig_level(lvl[1]),
    .run(ctrl.run), .ext_cnt(ctrl.ext_cnt), .cap_sel(ctrl.cap_sel),
    .trig_en(ctrl.trig_en), .rx_sel(ctrl.rx_sel), .tx_sel(ctrl.tx_sel),
    .updown(updown), .cnt_wr(cnt_wr), .pair_wr(pair_wr),
    .wdata(wr_data[HW-1:0]), .cnt(cnt), .pair(pair),
    .ovf_evt(ovf_evt), .ext_evt(ext_evt),
    .rx_pulse(rx_clk_pulse), .tx_pulse(tx_clk_pulse)
  );

  always_comb begin
    case (rd_addr)
      A_CTRL:   rd_data = ctrl;
      A_MODE:   rd_data = {{(DW-1){1'b0}}, updown};
      A_CNT_L:  rd_data = cnt[HW-1:0];
      A_CNT_H:  rd_data = cnt[CW-1:HW];
      A_PAIR_L: rd_data = pair[HW-1:0];
      A_PAIR_H: rd_data = pair[CW-1:HW];
      default:  rd_data = '0;
    endcase
  end

  // R9: up/down mode with only the trigger flag set keeps irq low
  p_irq_updown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (updown && !ctrl.ovf) |-> !irq);
endmodule

// File: tb/tb_cap_reload_timer.sv
module tb_cap_reload_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq, rx_clk_pulse, tx_clk_pulse;

  int compared = 0, mismatched = 0, cyc = 0, tick_div = 1;
  string phase = "R1";

  // reference model state
  logic [7:0]  m_ctrl = 8'h00;
  logic        m_ud = 1'b0, m_rx = 1'b0, m_tx = 1'b0;
  logic [15:0] m_cnt = 16'h0, m_pair = 16'h0;
  logic        cs1 = 1, cs2 = 1, cprev = 1, ts1 = 1, ts2 = 1, tprev = 1;

  always #4 clk = ~clk;

  cap_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .rx_clk_pulse(rx_clk_pulse), .tx_clk_pulse(tx_clk_pulse)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_ud = 0; m_rx = 0; m_tx = 0; m_cnt = 0; m_pair = 0;
      cs1 = 1; cs2 = 1; cprev = 1; ts1 = 1; ts2 = 1; tprev = 1;
    end else begin
      automatic bit baud = m_ctrl[5] || m_ctrl[4];
      automatic bit capm = m_ctrl[0] && !baud;
      automatic bit dn   = m_ud && !m_ctrl[0] && !baud;
      automatic bit cfall = tick_en && cprev && !cs2;
      automatic bit tfall = tick_en && tprev && !ts2;
      automatic bit cw  = wr_en && (wr_addr == 2 || wr_addr == 3);
      automatic bit adv = m_ctrl[2] && (m_ctrl[1] ? cfall : tick_en) && !cw;
      automatic bit up  = !dn || ts2;
      automatic bit ovf = adv && (up ? (m_cnt == 16'hFFFF) : (m_cnt == m_pair));
      automatic bit trg = tfall && m_ctrl[3] && !baud && !dn;
      automatic logic [15:0] nc = m_cnt, np = m_pair;
      automatic logic [7:0]  nctl = m_ctrl;
      if (ovf) begin
        if (!up) nc = 16'hFFFF;
        else if (capm) nc = 16'h0000;
        else nc = m_pair;
      end else if (adv) nc = up ? m_cnt + 16'd1 : m_cnt - 16'd1;
      if (trg) begin
        if (capm) np = m_cnt; else nc = m_pair;
      end
      if (wr_en) begin
        case (wr_addr)
          0: nctl = wr_data;
          1: m_ud = wr_data[0];
          2: nc[7:0] = wr_data;
          3: nc[15:8] = wr_data;
          4: np[7:0] = wr_data;
          5: np[15:8] = wr_data;
          default: ;
        endcase
      end
      if (ovf && !baud) nctl[7] = 1'b1;
      if (trg) nctl[6] = 1'b1;
      m_rx = ovf && m_ctrl[5];
      m_tx = ovf && m_ctrl[4];
      m_cnt = nc; m_pair = np; m_ctrl = nctl;
      if (tick_en) begin cprev = cs2; tprev = ts2; end
      cs2 = cs1; cs1 = cnt_pin; ts2 = ts1; ts1 = trig_pin;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      0: return m_ctrl;
      1: return {7'd0, m_ud};
      2: return m_cnt[7:0];
      3: return m_cnt[15:8];
      4: return m_pair[7:0];
      5: return m_pair[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic cmp(input string what, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: %s actual %h expected %h", phase, what, act, exp);
    end
  endtask

  // compare every clock, away from the rising edge; then advance tick and read address
  always @(negedge clk) begin
    cyc++;
    cmp($sformatf("rd_data[%0d]", rd_addr), {8'h0, rd_data}, {8'h0, exp_rd(rd_addr)});
    cmp("irq", {15'h0, irq}, {15'h0, m_ctrl[7] | (m_ctrl[6] & ~m_ud)});
    cmp("rx_clk_pulse", {15'h0, rx_clk_pulse}, {15'h0, m_rx});
    cmp("tx_clk_pulse", {15'h0, tx_clk_pulse}, {15'h0, m_tx});
    rd_addr <= (rd_addr == 3'd7) ? 3'd0 : rd_addr + 3'd1;
    tick_en <= ((cyc % tick_div) == 0);
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic trig_pulses(input int low, input int high, input int reps);
    for (int i = 0; i < reps; i++) begin
      trig_pin = 1'b0; wait_cyc(low);
      trig_pin = 1'b1; wait_cyc(high);
    end
  endtask

  task automatic cnt_toggles(input int half, input int reps);
    for (int i = 0; i < reps; i++) begin
      cnt_pin = 1'b0; wait_cyc(half);
      cnt_pin = 1'b1; wait_cyc(half);
    end
  endtask

  initial begin
    phase = "R1";
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(10);

    phase = "R2";
    wr(4, 8'h34); wr(5, 8'h12); wr(2, 8'hA5); wr(3, 8'h5A); wr(1, 8'h00);
    wr(0, 8'h00);
    wait_cyc(10);

    phase = "R3";
    wr(2, 8'h00); wr(3, 8'h00);
    wr(0, 8'h04);
    tick_div = 1; wait_cyc(20);
    tick_div = 3; wait_cyc(20);
    wr(2, 8'h77);
    wr(0, 8'h00); wait_cyc(12);

    phase = "R6";
    tick_div = 1;
    wr(4, 8'hF0); wr(5, 8'hFF); wr(2, 8'hFA); wr(3, 8'hFF);
    wr(0, 8'h04); wait_cyc(40);
    wr(4, 8'h00); wr(5, 8'h80); wr(0, 8'h0C);
    trig_pulses(3, 8, 4);
    wr(0, 8'h04);
    trig_pulses(3, 8, 3);

    phase = "R8";
    wr(0, 8'h04); wait_cyc(5);
    wr(0, 8'hC0); wait_cyc(8);
    wr(0, 8'h00); wait_cyc(5);

    phase = "R4";
    wr(2, 8'h00); wr(3, 8'h00); wr(0, 8'h06);
    cnt_toggles(3, 8);
    tick_div = 4; cnt_toggles(7, 6);
    tick_div = 1;

    phase = "R5";
    wr(2, 8'hF8); wr(3, 8'hFF); wr(0, 8'h0D);
    trig_pulses(4, 6, 6);
    tick_div = 2;
    wr(2, 8'hFC); wr(3, 8'hFF);
    trig_pulses(2, 3, 8);
    tick_div = 1;

    phase = "R7";
    wr(4, 8'hF8); wr(5, 8'hFF); wr(2, 8'hF0); wr(3, 8'hFF);
    wr(0, 8'h2D);
    trig_pulses(4, 6, 6);
    wr(0, 8'h14); wait_cyc(40);
    wr(0, 8'h34); wait_cyc(30);

    phase = "R10";
    wr(0, 8'h00); wr(1, 8'h01);
    wr(4, 8'h05); wr(5, 8'h00); wr(2, 8'h08); wr(3, 8'h00);
    trig_pin = 1'b1; wr(0, 8'h0C); wait_cyc(6);
    trig_pin = 1'b0; wait_cyc(12);
    trig_pin = 1'b1; wait_cyc(4);
    wr(2, 8'hFD); wr(3, 8'hFF); wait_cyc(8);
    trig_pulses(2, 4, 3);

    phase = "R9";
    wr(0, 8'h40); wait_cyc(4);
    wr(1, 8'h00); wait_cyc(4);
    wr(0, 8'h80); wait_cyc(4);
    wr(1, 8'h01); wait_cyc(4);
    wr(0, 8'h00); wait_cyc(4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule